// File: doc/BRIEF.md
# HDLC Transmit Framer with Idle Fill

This block turns a stream of payload bytes into a bit-stuffed HDLC line stream packed into octets. Each frame arrives on a valid/ready byte interface, and the caller marks the final byte with a last flag. The block wraps the frame in a 0x7E opening flag and a 0x7E closing flag. It appends a complemented CRC-16 and inserts a zero after every run of five ones inside the frame body. It serializes each byte least significant bit first. It packs the serial bits into output octets, with the first bit sent placed in the most significant position.

Between frames the line is never silent. In flag-fill mode the block sends 0x7E flags back to back, and they stay bit-aligned even when they straddle octet borders. In idle-fill mode it finishes the current octet with ones and then sends whole 0xFF octets. A rate-adaptation option carries only seven line bits per octet and forces the octet's least significant bit to 1. If the payload source runs dry before the last byte, the frame is aborted with a run of seven ones.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Payload and CRC bytes go onto the line least significant bit first, and line bits are packed into octets starting at bit 7, so the earliest line bit is the octet's MSB.
- R2: Inside a frame body (payload and CRC), a 0 is inserted after every five consecutive 1s. This holds across byte boundaries and directly before the closing flag. Flags are never stuffed.
- R3: The frame check sequence is a CRC-16 preset to 0xFFFF and updated over every payload byte with the bit-reflected polynomial 0x8408. It is inverted and sent low byte first, then high byte.
- R4: Every frame begins with one 0x7E flag and ends with one 0x7E flag.
- R5: With mode_dchan=0, the idle line carries back-to-back 0x7E flags with no extra bits between them. A frame opens only at a flag boundary, so flags rotate through octets without losing bit alignment.
- R6: With mode_dchan=1, after the closing flag the rest of the octet is filled with 1s, and only 0xFF octets follow until the next frame. An opening flag always starts on an octet boundary.
- R7: With mode_56k=1, each octet carries seven line bits in bits 7..1, and bit 0 is always 1.
- R8: If in_valid is low when the next byte of an unfinished frame is needed, the block sends seven 1s and returns to inter-frame fill.
- R9: The output never starves. With out_ready mostly high, a new octet appears at least every 20 cycles. While out_valid is high and out_ready is low, out_octet and out_valid hold.
- R10: After reset the line starts with fill at an octet boundary. The first octet is 0x7E (0x7F with mode_56k) in flag-fill mode and 0xFF in idle-fill mode.
- R11: in_ready is asserted only while in_valid is high and the framer needs a payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dchan | input | 1 | 1: all-ones idle fill; 0: continuous flag fill |
| mode_56k | input | 1 | 1: seven line bits per octet, LSB forced to 1 |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_last | input | 1 | Current byte is the last of its frame |
| in_ready | output | 1 | Payload byte taken this cycle |
| out_octet | output | 8 | Packed line octet |
| out_valid | output | 1 | out_octet holds a new octet |
| out_ready | input | 1 | Sink accepts the octet |

## Verification
The hardest conditions to reach from the ports are a stuffing run that crosses a byte boundary or ends right before the closing flag, and flags that rotate through seven-bit octets. The bench reaches the first with frames of 0xFF and 0x7E bytes. It reaches the second by running flag fill with the rate-adaptation option. It triggers an abort by withholding in_valid after three bytes of an unfinished frame. The bench deframes the captured line bits itself and compares each frame body bit for bit against a stuffed stream built from a serial CRC.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int OCT_W = 8;
  localparam int CRC_W = 16;
  localparam logic [OCT_W-1:0] FLAG_PAT = 8'h7E;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_OPEN,
    ST_BODY,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

  // Byte-wide update of the reflected CRC-16, data taken LSB first.
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c,
                                                  input logic [OCT_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < OCT_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_bitgen.sv
module hdlc_tx_bitgen
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_dchan,
  input  logic             at_octet_start,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             bit_valid,
  output logic             bit_val,
  input  logic             bit_go
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam int AB_W  = $clog2(ABORT_LEN + 1);
  localparam int CNT_W = $clog2(OCT_W + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);
  localparam logic [AB_W-1:0]  AB_LAST = AB_W'(ABORT_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OCT_W);

  tx_state_e        st;
  logic [2:0]       fidx;
  logic [OCT_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [RUN_W-1:0] ones;
  logic [AB_W-1:0]  acnt;
  logic [CRC_W-1:0] crc;
  logic             last_q, is_crc, crc_hi;

  // Named internal events.
  logic stuff_now, need_dec, start_ok, want_byte, abort_start;

  assign stuff_now   = (st == ST_BODY) && (ones == RUN_MAX);
  assign need_dec    = (st == ST_BODY) && !stuff_now && (cnt == '0);
  assign start_ok    = (st == ST_FILL) && in_valid &&
                       (mode_dchan ? at_octet_start : (fidx == 3'd0));
  assign want_byte   = need_dec && !is_crc && !last_q;
  assign abort_start = want_byte && !in_valid;
  assign in_ready    = want_byte && in_valid;
  assign bit_valid   = !(need_dec || start_ok);

  always_comb begin
    case (st)
      ST_FILL:  bit_val = mode_dchan ? 1'b1 : FLAG_PAT[fidx];
      ST_OPEN,
      ST_CLOSE: bit_val = FLAG_PAT[fidx];
      ST_BODY:  bit_val = stuff_now ? 1'b0 : sh[0];
      default:  bit_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FILL;
      fidx   <= '0;
      sh     <= '0;
      cnt    <= '0;
      ones   <= '0;
      acnt   <= '0;
      crc    <= CRC_PRESET;
      last_q <= 1'b0;
      is_crc <= 1'b0;
      crc_hi <= 1'b0;
    end else if (start_ok) begin
      st   <= ST_OPEN;
      fidx <= '0;
    end else if (need_dec) begin
      if (want_byte) begin
        if (in_valid) begin
          sh     <= in_data;
          cnt    <= CNT_FULL;
          crc    <= crc16_byte(crc, in_data);
          last_q <= in_last;
        end else begin
          st   <= ST_ABORT;
          acnt <= '0;
        end
      end else if (!is_crc) begin
        sh     <= ~crc[7:0];
        cnt    <= CNT_FULL;
        is_crc <= 1'b1;
      end else if (!crc_hi) begin
        sh     <= ~crc[15:8];
        cnt    <= CNT_FULL;
        crc_hi <= 1'b1;
      end else begin
        st   <= ST_CLOSE;
        fidx <= '0;
      end
    end else if (bit_go) begin
      case (st)
        ST_FILL: fidx <= fidx + 3'd1;
        ST_OPEN: begin
          fidx <= fidx + 3'd1;
          if (fidx == 3'd7) begin
            st     <= ST_BODY;
            cnt    <= '0;
            ones   <= '0;
            last_q <= 1'b0;
            is_crc <= 1'b0;
            crc_hi <= 1'b0;
            crc    <= CRC_PRESET;
          end
        end
        ST_BODY: begin
          if (stuff_now) ones <= '0;
          else begin
            sh   <= {1'b0, sh[OCT_W-1:1]};
            cnt  <= cnt - 1'b1;
            ones <= sh[0] ? ones + 1'b1 : '0;
          end
        end
        ST_CLOSE: begin
          fidx <= fidx + 3'd1;
          if (fidx == 3'd7) st <= ST_FILL;
        end
        default: begin
          acnt <= acnt + 1'b1;
          if (acnt == AB_LAST) begin
            st   <= ST_FILL;
            fidx <= '0;
          end
        end
      endcase
    end
  end

  // R2
  stuff_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY) |-> (ones <= RUN_MAX));
  // R2
  stuff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_now && bit_go) |=> (ones == '0));
  // R8
  abort_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_start |=> (st == ST_ABORT) && (acnt == '0));
  // R8
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ABORT) && bit_go && (acnt == AB_LAST)) |=> (st == ST_FILL) && (fidx == 3'd0));
  // R11
  rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_valid && (st == ST_BODY) && !last_q));

endmodule

// File: rtl/hdlc_tx_packer.sv
module hdlc_tx_packer
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_56k,
  input  logic             bit_valid,
  input  logic             bit_val,
  output logic             bit_take,
  output logic             at_octet_start,
  output logic [OCT_W-1:0] out_octet,
  output logic             out_valid,
  input  logic             out_ready
);

  localparam int CNT_W = $clog2(OCT_W + 1);
  localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(OCT_W);
  localparam logic [CNT_W-1:0] LIM_ADPT = CNT_W'(OCT_W - 1);

  logic [OCT_W-2:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fill_lim;
  logic             slot_free, octet_done;

  assign slot_free      = !out_valid || out_ready;
  assign bit_take       = bit_valid && slot_free;
  assign fill_lim       = mode_56k ? LIM_ADPT : LIM_FULL;
  assign octet_done     = bit_take && ((cnt + 1'b1) == fill_lim);
  assign at_octet_start = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      out_octet <= '0;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (octet_done) begin
        out_octet <= mode_56k ? {acc[OCT_W-3:0], bit_val, 1'b1} : {acc, bit_val};
        out_valid <= 1'b1;
        cnt       <= '0;
      end else if (bit_take) begin
        acc <= {acc[OCT_W-3:0], bit_val};
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_octet)));
  // R7
  pad_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_56k) |-> out_octet[0]);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_dchan,
  input  logic       mode_56k,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_octet,
  output logic       out_valid,
  input  logic       out_ready
);

  logic bit_valid, bit_val, bit_take, at_octet_start;

  hdlc_tx_bitgen #(.STUFF_RUN(STUFF_RUN), .ABORT_LEN(ABORT_LEN)) u_bitgen (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_dchan     (mode_dchan),
    .at_octet_start (at_octet_start),
    .in_data        (in_data),
    .in_valid       (in_valid),
    .in_last        (in_last),
    .in_ready       (in_ready),
    .bit_valid      (bit_valid),
    .bit_val        (bit_val),
    .bit_go         (bit_take)
  );

  hdlc_tx_packer u_packer (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_56k       (mode_56k),
    .bit_valid      (bit_valid),
    .bit_val        (bit_val),
    .bit_take       (bit_take),
    .at_octet_start (at_octet_start),
    .out_octet      (out_octet),
    .out_valid      (out_valid),
    .out_ready      (out_ready)
  );

  // R9
  take_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |-> bit_valid);

endmodule

// File: tb/hdlc_tx_framer_test.sv
`timescale 1ns/1ps
module hdlc_tx_framer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_dchan = 1'b0;
  logic       mode_56k = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_octet;
  logic       out_valid;
  logic       out_ready = 1'b1;

  always #10 clk = ~clk;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .mode_dchan(mode_dchan), .mode_56k(mode_56k),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_octet(out_octet), .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0;
  int fails  = 0;

  bit rx [0:16383];
  int nbits, noct, cyc, gap, max_gap, lsb_bad, bad_rdy;
  logic [7:0] first_oct;
  bit cap_en = 1'b0;

  logic [7:0] fr_data [0:4][0:15];
  int  fr_len [0:4];
  bit  fr_abort [0:4];
  bit  exp_bits [0:1023];
  int  exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Capture: values set here are the ones seen at the next rising edge.
  always @(negedge clk) begin
    if (cap_en) begin
      cyc++;
      out_ready = ((cyc % 5) != 3);
      gap++;
      if (out_valid && out_ready) begin
        if (noct == 0) first_oct = out_octet;
        noct++;
        if (gap > max_gap) max_gap = gap;
        gap = 0;
        if (mode_56k) begin
          if (!out_octet[0]) lsb_bad++;
          for (int b = 7; b >= 1; b--) begin rx[nbits] = out_octet[b]; nbits++; end
        end else begin
          for (int b = 7; b >= 0; b--) begin rx[nbits] = out_octet[b]; nbits++; end
        end
      end
      #2;
      if (in_ready && !in_valid) bad_rdy++;
    end
  end

  function automatic bit is_flag(input int p);
    return (rx[p] == 0) && rx[p+1] && rx[p+2] && rx[p+3] && rx[p+4] &&
           rx[p+5] && rx[p+6] && (rx[p+7] == 0);
  endfunction

  // Expected stuffed body: bit-serial CRC, LSB-first bytes, zero after five 1s.
  task automatic build_exp(input int j);
    logic [15:0] c;
    int run;
    bit bv, fb;
    c = 16'hFFFF; run = 0; exp_n = 0;
    for (int i = 0; i < fr_len[j]; i++) begin
      for (int b = 0; b < 8; b++) begin
        bv = fr_data[j][i][b];
        fb = c[0] ^ bv;
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
        exp_bits[exp_n] = bv; exp_n++;
        run = bv ? run + 1 : 0;
        if (run == 5) begin exp_bits[exp_n] = 1'b0; exp_n++; run = 0; end
      end
    end
    c = ~c;
    for (int b = 0; b < 16; b++) begin
      bv = c[b];
      exp_bits[exp_n] = bv; exp_n++;
      run = bv ? run + 1 : 0;
      if (run == 5) begin exp_bits[exp_n] = 1'b0; exp_n++; run = 0; end
    end
  endtask

  task automatic send_frame(input int j);
    int n;
    n = fr_abort[j] ? 3 : fr_len[j];
    for (int i = 0; i < n; i++) begin
      in_data  = fr_data[j][i];
      in_valid = 1'b1;
      in_last  = !fr_abort[j] && (i == n - 1);
      forever begin
        #1;
        if (in_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic parse(input bit d, input int bpo, input string tag);
    bit body [0:1023];
    int p, q, last, blen, run, fi, bfill, junk, alignbad, abort_at, mism;
    bit ab, done, abort_recent;
    p = 0; last = 0; fi = 0; bfill = 0; junk = 0; alignbad = 0;
    abort_at = -1; abort_recent = 0;
    while ((p + 8 <= nbits) && (fi < 5)) begin
      if (is_flag(p)) begin
        if (last == 2) last = d ? 3 : 1;
        else begin
          if (d && ((p % bpo) != 0)) alignbad++;
          last = 1;
        end
        abort_recent = 0;
        p += 8;
      end else if (last == 1) begin
        q = p; run = 0; blen = 0; ab = 0; done = 0;
        while ((q + 8 <= nbits) && !done) begin
          if (is_flag(q)) done = 1;
          else begin
            body[blen] = rx[q]; blen++;
            run = rx[q] ? run + 1 : 0;
            q++;
            if (run == 7) begin done = 1; ab = 1; end
          end
        end
        if (!done) p = nbits;
        else if (ab) begin
          // R8: only the starved frame may end in seven ones
          chk(fr_abort[fi], "R8", {tag, " abort on frame"}, fi, 2);
          abort_at = fi; fi++; p = q; last = 0; abort_recent = 1;
        end else begin
          chk(!fr_abort[fi], "R8", {tag, " starved frame closed normally"}, fi, 2);
          build_exp(fi);
          // R2: stuffed length
          chk(blen == exp_n, "R2", {tag, " body bit count"}, blen, exp_n);
          mism = -1;
          for (int k = 0; k < blen && k < exp_n; k++)
            if ((mism < 0) && (body[k] != exp_bits[k])) mism = k;
          // R1 R3: bit order and check sequence
          chk(mism < 0, "R1 R3", {tag, " first differing body bit"}, mism, -1);
          fi++; p = q; last = 2;
        end
      end else begin
        if (rx[p]) begin
          if (!d && !abort_recent) bfill++;
        end else junk++;
        p++;
        last = 0;
      end
    end
    // R4
    chk(fi == 5, "R4", {tag, " frames delimited by flags"}, fi, 5);
    // R8
    chk(abort_at == 2, "R8", {tag, " aborted frame index"}, abort_at, 2);
    if (!d) chk(bfill == 0, "R5", {tag, " stray ones between flags"}, bfill, 0);
    else    chk(alignbad == 0, "R6", {tag, " misaligned opening flags"}, alignbad, 0);
    chk(junk == 0, d ? "R6" : "R5", {tag, " zero bits in fill"}, junk, 0);
  endtask

  task automatic run_cfg(input bit d, input bit m);
    string tag;
    logic [7:0] exp_first;
    tag = $sformatf("cfg d=%0d m=%0d", d, m);
    @(negedge clk);
    rst_n = 1'b0; mode_dchan = d; mode_56k = m;
    nbits = 0; noct = 0; cyc = 0; gap = 0; max_gap = 0; lsb_bad = 0; bad_rdy = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; cap_en = 1'b1;
    repeat (20) @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      send_frame(j);
      repeat (40) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    cap_en = 1'b0;
    out_ready = 1'b1;
    // R10: fill starts at an octet boundary
    if (d) exp_first = 8'hFF;
    else   exp_first = m ? 8'h7F : 8'h7E;
    chk(first_oct == exp_first, "R10", {tag, " first octet"}, first_oct, exp_first);
    // R9
    chk(max_gap <= 20, "R9", {tag, " longest cycle gap between octets"}, max_gap, 20);
    // R7
    if (m) chk(lsb_bad == 0, "R7", {tag, " octets with bit0 clear"}, lsb_bad, 0);
    // R11
    chk(bad_rdy == 0, "R11", {tag, " ready without valid"}, bad_rdy, 0);
    parse(d, m ? 7 : 8, tag);
  endtask

  initial begin
    logic [7:0] x;
    fr_len[0] = 1;  fr_abort[0] = 0; fr_data[0][0] = 8'hA5;
    fr_len[1] = 4;  fr_abort[1] = 0;
    for (int i = 0; i < 16; i++) fr_data[1][i] = 8'hFF;
    fr_len[2] = 8;  fr_abort[2] = 1;
    for (int i = 0; i < 16; i++) fr_data[2][i] = 8'h3C + 8'(i);
    fr_len[3] = 6;  fr_abort[3] = 0;
    for (int i = 0; i < 16; i++) fr_data[3][i] = 8'h7E;
    fr_len[4] = 16; fr_abort[4] = 0;
    x = 8'h5B;
    for (int i = 0; i < 16; i++) begin x = x * 8'd13 + 8'd7; fr_data[4][i] = x; end
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 2; m++)
        run_cfg(d[0], m[0]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule